// File: doc/BRIEF.md
# Dual-Mode Clock Configuration Sequencer

This block runs each performance-state change for a clock network that can work either as a resonant tank or as a plain direct-driven grid. A request carries the index of the target frequency. The sequencer then does the following, in order:

1. It stops the core clock.
2. It forces the network into direct-drive mode: all mode-switch banks open and the throttle switch closed.
3. It reads the configuration word for that frequency from a 16-entry table.
4. It sends the word's driver fields to every driver site over a parallel bus qualified by a strobe.
5. If the new setting is resonant, it closes the mode-switch banks one after another, a fixed number of cycles apart.
6. It releases the clock gate and pulses done.

The table is written through a simple write port. A request that arrives during a transition is held and started once the current one has finished.

Top module: `dualclk_cfg_seq`

## Requirements
- R1: After reset, gate_en, msw_en, bcast_strobe and done are 0 and tsw_on is 1.
- R2: A request seen at a clock edge while idle makes gate_en 1 and msw_en all zeros right after that edge.
- R3: bcast_strobe is only ever 1 while gate_en is 1 and msw_en is all zeros.
- R4: The broadcast word comes from the table entry at the requested index. Table word layout: bit 7 is the mode (1 = resonant), bits 6:4 are drive strength, bit 3 is pulse enable, bits 2:0 are duty cycle.
- R5: The broadcast is one strobe cycle per site. Sites go in ascending order 0 to NSITE-1 on consecutive cycles, starting two edges after acceptance. bcast_data is {strength, pulse, duty}.
- R6: For a resonant target, banks close as a thermometer from bit 0, one bank per STAGE_CYC cycles. The first bank closes on the edge after the last strobe. No bank closes while gate_en is 0.
- R7: For a conventional target, msw_en stays all zeros and tsw_on stays 1 for the whole transition.
- R8: tsw_on is 1 exactly when msw_en is all zeros.
- R9: gate_en falls only after the broadcast and any staging have finished. done is a one-cycle pulse on the same edge. For a conventional target this is 7 edges after acceptance; for a resonant target it is 8 + (NBANK-1)*STAGE_CYC edges after acceptance.
- R10: A request that arrives during a transition is held. Its transition starts on the edge after done rises.
- R11: Every transition starts from conventional mode, including resonant-to-resonant changes. All banks open on the acceptance edge.
- R12: A stored strength of 0 is broadcast as 1, because valid strengths are 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transition request |
| req_idx | input | IDX_W | Target frequency index |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | IDX_W | Table write address |
| tbl_wdata | input | WORD_W | Table write word |
| gate_en | output | 1 | Core clock gated while 1 |
| msw_en | output | NBANK | Mode-switch bank closes |
| tsw_on | output | 1 | Throttle switch closed |
| bcast_strobe | output | 1 | Forwarded strobe of the broadcast link |
| bcast_site | output | SITE_W | Site address of the current word |
| bcast_data | output | WORD_W-1 | Strength, pulse enable, duty cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Five transitions are run against a model of the expected strobe words and of the bank count in each cycle:

- **Conventional target:** shows that no staging happens, and that the release comes at the short latency.
- **Resonant target:** shows the thermometer staging and the throttle handover.
- **Resonant to resonant:** shows that all banks open first.
- **Zero-strength entry:** shows the clamp to the minimum strength.
- **Request injected mid-transition:** shows that the request is held and then started straight after done.

// File: rtl/dualclk_cfg_seq.sv
module dualclk_cfg_seq #(
  parameter int NBANK     = 4,
  parameter int NSITE     = 4,
  parameter int STAGE_CYC = 4,
  parameter int IDX_W     = 4,
  parameter int STR_W     = 3,
  parameter int DUTY_W    = 3,
  localparam int WORD_W   = 2 + STR_W + DUTY_W,
  localparam int SITE_W   = (NSITE > 1) ? $clog2(NSITE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic                tbl_we,
  input  logic [IDX_W-1:0]    tbl_waddr,
  input  logic [WORD_W-1:0]   tbl_wdata,
  output logic                gate_en,
  output logic [NBANK-1:0]    msw_en,
  output logic                tsw_on,
  output logic                bcast_strobe,
  output logic [SITE_W-1:0]   bcast_site,
  output logic [WORD_W-2:0]   bcast_data,
  output logic                done
);
  localparam int TBL_N = 1 << IDX_W;
  localparam int CNT_W = $clog2(STAGE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_SEND, S_STAGE, S_REL} st_t;

  st_t                 st;
  logic [WORD_W-1:0]   tbl [TBL_N];
  logic [WORD_W-1:0]   cfg_r;
  logic [IDX_W-1:0]    idx_r, pend_idx;
  logic                pend;
  logic [SITE_W-1:0]   site_r;
  logic [CNT_W-1:0]    cnt;
  logic [STR_W-1:0]    str_raw, str_fix;
  logic                cfg_res;

  assign cfg_res = cfg_r[WORD_W-1];
  assign str_raw = cfg_r[WORD_W-2 -: STR_W];
  assign str_fix = (str_raw == '0) ? STR_W'(1) : str_raw;

  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_waddr] <= tbl_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      gate_en      <= 1'b0;
      msw_en       <= '0;
      tsw_on       <= 1'b1;
      bcast_strobe <= 1'b0;
      bcast_site   <= '0;
      bcast_data   <= '0;
      done         <= 1'b0;
      cfg_r        <= '0;
      idx_r        <= '0;
      pend         <= 1'b0;
      pend_idx     <= '0;
      site_r       <= '0;
      cnt          <= '0;
    end else begin
      if (st != S_IDLE && req_valid) begin
        pend     <= 1'b1;
        pend_idx <= req_idx;
      end
      case (st)
        S_IDLE: begin
          done <= 1'b0;
          if (pend || req_valid) begin
            idx_r   <= pend ? pend_idx : req_idx;
            gate_en <= 1'b1;
            msw_en  <= '0;
            tsw_on  <= 1'b1;
            cnt     <= '0;
            site_r  <= '0;
            st      <= S_LOOK;
            pend    <= pend && req_valid;
            if (pend && req_valid) pend_idx <= req_idx;
          end
        end
        S_LOOK: begin
          cfg_r <= tbl[idx_r];
          st    <= S_SEND;
        end
        S_SEND: begin
          bcast_strobe <= 1'b1;
          bcast_site   <= site_r;
          bcast_data   <= {str_fix, cfg_r[DUTY_W:0]};
          if (site_r == SITE_W'(NSITE - 1)) st <= S_STAGE;
          else site_r <= site_r + 1'b1;
        end
        S_STAGE: begin
          bcast_strobe <= 1'b0;
          if (!cfg_res || (&msw_en)) begin
            st <= S_REL;
          end else if (cnt == '0) begin
            msw_en <= (msw_en << 1) | NBANK'(1);
            tsw_on <= 1'b0;
            cnt    <= CNT_W'(STAGE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_REL: begin
          gate_en <= 1'b0;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dualclk_cfg_seq_chk.sv
module dualclk_cfg_seq_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en,
  input logic [NBANK-1:0] msw_en,
  input logic             tsw_on,
  input logic             bcast_strobe,
  input logic             done
);
  // R3
  strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_strobe |-> (gate_en && msw_en == '0));

  // R8
  throttle_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tsw_on == (msw_en == '0));

  // R6
  bank_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msw_en & (msw_en + 1'b1)) == '0);

  // R6
  bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(msw_en) <= $countones($past(msw_en)) + 1);

  // R6
  bank_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(msw_en) > $countones($past(msw_en))) |-> gate_en);

  // R9
  release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_en) |-> done);

  // R9
  done_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !gate_en);

  // R11
  gate_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> (msw_en == '0 && tsw_on));
endmodule

bind dualclk_cfg_seq dualclk_cfg_seq_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .msw_en(msw_en),
  .tsw_on(tsw_on), .bcast_strobe(bcast_strobe), .done(done));

// File: tb/dualclk_cfg_seq_bench.sv
module dualclk_cfg_seq_bench;
  localparam int PERIOD = 10;
  localparam int NB = 4, NS = 4, SC = 3;

  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, tbl_we = 0;
  logic [3:0] req_idx = 0, tbl_waddr = 0;
  logic [7:0] tbl_wdata = 0;
  logic       gate_en, tsw_on, bcast_strobe, done;
  logic [NB-1:0] msw_en;
  logic [1:0] bcast_site;
  logic [6:0] bcast_data;

  int nchk = 0, nfail = 0;
  logic [8:0] q[$];

  always #(PERIOD/2) clk = ~clk;

  dualclk_cfg_seq #(.NBANK(NB), .NSITE(NS), .STAGE_CYC(SC)) u_dualclk_cfg_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .gate_en(gate_en), .msw_en(msw_en), .tsw_on(tsw_on),
    .bcast_strobe(bcast_strobe), .bcast_site(bcast_site),
    .bcast_data(bcast_data), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected strobe words (R4 R5 R12) and checks R3
  initial forever begin
    @(negedge clk);
    if (rst_n && bcast_strobe) begin
      chk(gate_en && msw_en == 0, "R3", {gate_en, msw_en}, 5'b10000);
      if (q.size() == 0) chk(0, "R5 unexpected strobe", {bcast_site, bcast_data}, 0);
      else begin
        logic [8:0] e;
        e = q.pop_front();
        chk({bcast_site, bcast_data} == e, "R4 R5 word", {bcast_site, bcast_data}, e);
      end
    end
  end

  task automatic wr(input int a, input logic [7:0] w);
    @(negedge clk);
    tbl_we = 1; tbl_waddr = 4'(a); tbl_wdata = w;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic do_trans(input logic [7:0] w, input int idx, input bit drive,
                          input bit inject, input int inj_idx);
    logic [2:0] s;
    bit res;
    int done_n;
    s = (w[6:4] == 0) ? 3'd1 : w[6:4];
    res = w[7];
    done_n = res ? 8 + (NB-1)*SC : 7;
    for (int k = 0; k < NS; k++) q.push_back({2'(k), s, w[3:0]});
    if (drive) begin req_valid = 1; req_idx = 4'(idx); end
    for (int n = 0; n <= done_n; n++) begin
      int ec;
      @(negedge clk);
      if (n == 0) req_valid = 0;
      if (inject && n == 3) begin req_valid = 1; req_idx = 4'(inj_idx); end
      if (inject && n == 4) req_valid = 0;
      ec = 0;
      if (res && n >= 6) ec = ((n-6)/SC + 1 > NB) ? NB : (n-6)/SC + 1;
      if (n == 0) chk(gate_en == 1 && msw_en == 0, "R2 R10 R11 accept", {gate_en, msw_en}, 5'b10000);
      if (n < done_n) chk(gate_en == 1, "R9 gate held", gate_en, 1);
      else chk(gate_en == 0, "R9 gate release", gate_en, 0);
      chk(done == (n == done_n), "R9 done pulse", done, n == done_n);
      chk($countones(msw_en) == ec && msw_en == NB'((1 << ec) - 1),
          res ? "R6 bank stage" : "R7 banks open", msw_en, (1 << ec) - 1);
      chk(tsw_on == (ec == 0), "R8 throttle", tsw_on, ec == 0);
    end
    chk(q.size() == 0, "R5 strobe count", q.size(), 0);
  endtask

  initial begin
    #(PERIOD*200000);
    nfail++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gate_en == 0 && msw_en == 0 && bcast_strobe == 0 && done == 0 && tsw_on == 1,
        "R1 reset", {gate_en, msw_en, bcast_strobe, done, tsw_on}, 1);
    rst_n = 1;
    wr(2,  {1'b0, 3'd3, 1'b1, 3'd5});
    wr(5,  {1'b1, 3'd7, 1'b0, 3'd2});
    wr(9,  {1'b1, 3'd0, 1'b1, 3'd7});
    wr(12, {1'b0, 3'd5, 1'b0, 3'd1});
    @(negedge clk);
    do_trans({1'b0, 3'd3, 1'b1, 3'd5}, 2, 1, 0, 0);   // R7 conventional
    repeat (2) @(negedge clk);
    do_trans({1'b1, 3'd7, 1'b0, 3'd2}, 5, 1, 0, 0);   // R6 resonant
    repeat (2) @(negedge clk);
    do_trans({1'b1, 3'd0, 1'b1, 3'd7}, 9, 1, 0, 0);   // R11 res->res, R12 clamp
    repeat (2) @(negedge clk);
    do_trans({1'b0, 3'd5, 1'b0, 3'd1}, 12, 1, 1, 5);  // R10 inject
    do_trans({1'b1, 3'd7, 1'b0, 3'd2}, 5, 0, 0, 0);   // R10 held request served
    repeat (3) @(negedge clk);
    chk(gate_en == 0 && done == 0, "R10 no extra transition", gate_en, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule